// File: doc/BRIEF.md
# Self-Correcting Gray Code Counter

This block is a free-running reflected-binary Gray code counter that needs no power-on reset to work correctly over time. After power-up, or after a particle strike, the count register and the direction register may hold any value, so the counter may start out counting backward. A small detector watches for the one step that only a backward counter can make: leaving code zero toward the all-ones binary value. When it sees that step, it sets the direction to forward. From then on the counter counts forward and wraps from its top code back to zero without changing direction.

A synchronous reset is provided only as a convenience for simulation. A preset port loads any code and direction. Tests use it to model an arbitrary power-up state or an upset of either register. The enable input gates the stepping.

Top module: `sc_gray_counter`

## Requirements
- R1: With `rst` high at a clock edge, the next `code` is 0 and `fwd` is 1. `rst` has priority over `ld` and `en`.
- R2: With `rst`, `ld` and `en` all low at a clock edge, `code` and `fwd` keep their values.
- R3: When enabled and counting forward (`fwd`=1), the binary equivalent of `code` rises by one modulo 2^W. Exactly one bit of `code` changes per step.
- R4: When enabled and counting backward (`fwd`=0) from a nonzero code, the binary equivalent of `code` falls by one and `fwd` stays 0.
- R5: When enabled and counting backward at code 0, the next `code` has only its top bit set (the Gray form of 2^W-1), and `fwd` becomes 1.
- R6: When counting forward at code 1 followed by W-1 zeros, an enabled step gives code 0, and `fwd` stays 1.
- R7: With `ld` high and `rst` low, the next `code` equals `ld_code` and `fwd` equals `ld_fwd`, whatever `en` is.
- R8: From any loaded state, `fwd` is 1 after at most 2^W+1 enabled steps and stays 1 after that.
- R9: `fwd` reports the direction register, where 1 means forward and 0 means backward. The binary equivalent of `code` is defined with bit i = XOR of `code` bits W-1 down to i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, for simulation convenience |
| en | input | 1 | Count enable |
| ld | input | 1 | Preset strobe that models a power-up or upset state |
| ld_code | input | W | Gray code loaded by `ld` |
| ld_fwd | input | 1 | Direction loaded by `ld` (1 = forward) |
| code | output | W | Current Gray count |
| fwd | output | 1 | Direction valid: 1 when counting forward |

## Verification
Directed patterns cover the following cases:
- Loads at code zero with backward direction, which isolate the corrective wrap.
- Loads at the top code with forward direction, which show that an ordinary wrap leaves the direction alone.
- Backward loads at interior codes, which separate a plain decrement from a correction.
- Enable-low stretches, which show the hold behaviour.

Random loads of both registers, followed by runs with the enable toggled at random, model arbitrary power-up states and upsets. In each run the cycle at which the counter turns forward is timed against the 2^W+1 bound. A reset asserted together with a load tells the two priorities apart.

// File: rtl/gc_pkg.sv
package gc_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Direction after one enabled step: a step off code zero while
    // counting down is only possible for a reversed counter.
    function automatic dir_e step_dir(input dir_e cur, input logic at_zero);
        if (cur == DIR_DOWN && at_zero) return DIR_UP;
        return cur;
    endfunction
endpackage

// File: rtl/gc_g2b.sv
module gc_g2b #(
    parameter int W = 8
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    assign bin[W-1] = gray[W-1];
    for (genvar i = W - 2; i >= 0; i--) begin : g_xor
        assign bin[i] = bin[i+1] ^ gray[i];
    end
endmodule

// File: rtl/gc_next.sv
module gc_next
    import gc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_code,
    input  dir_e         cur_dir,
    output logic [W-1:0] nxt_code,
    output dir_e         nxt_dir,
    output logic         bad_wrap
);
    logic [W-1:0] cur_bin;
    logic [W-1:0] nxt_bin;
    logic         at_zero;

    gc_g2b #(.W(W)) u_g2b (.gray(cur_code), .bin(cur_bin));

    assign at_zero  = (cur_code == '0);
    assign bad_wrap = (cur_dir == DIR_DOWN) && at_zero;

    always_comb begin
        if (cur_dir == DIR_UP) nxt_bin = cur_bin + 1'b1;
        else                   nxt_bin = cur_bin - 1'b1;
    end

    assign nxt_code = nxt_bin ^ (nxt_bin >> 1);
    assign nxt_dir  = step_dir(cur_dir, at_zero);
endmodule

// File: rtl/gc_reg.sv
module gc_reg
    import gc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] ld_code,
    input  dir_e         ld_dir,
    input  logic [W-1:0] nxt_code,
    input  dir_e         nxt_dir,
    output logic [W-1:0] code_q,
    output dir_e         dir_q
);
    localparam logic [W-1:0] TOP_CODE = {1'b1, {(W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            dir_q  <= DIR_UP;
        end else if (ld) begin
            code_q <= ld_code;
            dir_q  <= ld_dir;
        end else if (en) begin
            code_q <= nxt_code;
            dir_q  <= nxt_dir;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (code_q == '0) && (dir_q == DIR_UP));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ld && !en) |=> $stable(code_q) && $stable(dir_q));

    p_one_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (!ld && en) |=> ($countones(code_q ^ $past(code_q)) == 1));

    p_fix_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!ld && en && dir_q == DIR_DOWN && code_q == '0)
        |=> (dir_q == DIR_UP) && (code_q == TOP_CODE));

    p_top_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!ld && en && dir_q == DIR_UP && code_q == TOP_CODE)
        |=> (dir_q == DIR_UP) && (code_q == '0));

    p_stay_up_r8: assert property (@(posedge clk) disable iff (rst)
        (!ld && dir_q == DIR_UP) |=> (dir_q == DIR_UP));

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        ld |=> (code_q == $past(ld_code)) && (dir_q == $past(ld_dir)));
endmodule

// File: rtl/sc_gray_counter.sv
module sc_gray_counter
    import gc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] ld_code,
    input  logic         ld_fwd,
    output logic [W-1:0] code,
    output logic         fwd
);
    localparam int CW = W + 2;
    localparam logic [CW-1:0] BOUND = CW'(1) << W;

    logic [W-1:0] code_q, nxt_code;
    dir_e         dir_q, nxt_dir, ld_dir;
    logic         bad_wrap;

    assign ld_dir = ld_fwd ? DIR_UP : DIR_DOWN;

    gc_next #(.W(W)) u_next (
        .cur_code (code_q),
        .cur_dir  (dir_q),
        .nxt_code (nxt_code),
        .nxt_dir  (nxt_dir),
        .bad_wrap (bad_wrap)
    );

    gc_reg #(.W(W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ld       (ld),
        .ld_code  (ld_code),
        .ld_dir   (ld_dir),
        .nxt_code (nxt_code),
        .nxt_dir  (nxt_dir),
        .code_q   (code_q),
        .dir_q    (dir_q)
    );

    assign code = code_q;
    assign fwd  = (dir_q == DIR_UP);

    // Checker: enabled steps spent counting backward since the last load.
    logic [CW-1:0] back_steps;
    always_ff @(posedge clk) begin
        if (rst || ld || dir_q == DIR_UP) back_steps <= '0;
        else if (en)                      back_steps <= back_steps + 1'b1;
    end

    p_recover_bound_r8: assert property (@(posedge clk) disable iff (rst)
        back_steps <= BOUND);

    p_wrap_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (!ld && en && bad_wrap) |=> fwd);
endmodule

// File: tb/sc_gray_counter_tb.sv
module sc_gray_counter_tb;
    localparam int W = 8;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         ld = 1'b0;
    logic [W-1:0] ld_code = '0;
    logic         ld_fwd = 1'b0;
    logic [W-1:0] code;
    logic         fwd;

    int checks = 0;
    int fails  = 0;
    int ref_bin = 0;
    int ref_fwd = 1;
    bit done = 0;

    always #10 clk = ~clk;

    sc_gray_counter #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .ld(ld),
        .ld_code(ld_code), .ld_fwd(ld_fwd),
        .code(code), .fwd(fwd)
    );

    function automatic int to_bin(input logic [W-1:0] g);
        int acc = 0;
        int b = 0;
        for (int i = W - 1; i >= 0; i--) begin
            b = b ^ int'(g[i]);
            acc = acc * 2 + b;
        end
        return acc;
    endfunction

    function automatic logic [W-1:0] to_gray(input int b);
        int v = b ^ (b / 2);
        return v[W-1:0];
    endfunction

    // Reference model, stepped on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            ref_bin = 0; ref_fwd = 1;
        end else if (ld) begin
            ref_bin = to_bin(ld_code); ref_fwd = int'(ld_fwd);
        end else if (en) begin
            if (ref_fwd == 1)    ref_bin = (ref_bin + 1) % M;
            else if (ref_bin == 0) begin ref_bin = M - 1; ref_fwd = 1; end
            else                 ref_bin = ref_bin - 1;
        end
    end

    task automatic compare(input string tag);
        checks++;
        if (code !== to_gray(ref_bin) || fwd !== ref_fwd[0]) begin
            fails++;
            $display("FAIL %s: code=%h fwd=%0d expected code=%h fwd=%0d",
                     tag, code, fwd, to_gray(ref_bin), ref_fwd);
        end
    endtask

    task automatic cyc(input logic r, input logic e, input logic l,
                       input logic [W-1:0] c, input logic f, input string tag);
        rst = r; en = e; ld = l; ld_code = c; ld_fwd = f;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        cyc(1, 0, 0, '0, 0, "R1");
        cyc(1, 1, 0, '0, 0, "R1");
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, '0, 0, "R3");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0, 0, "R2");
        cyc(0, 0, 1, to_gray(5), 0, "R7");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0, 0, "R4");
        cyc(0, 1, 0, '0, 0, "R4");
        cyc(0, 1, 0, '0, 0, "R5");
        cyc(0, 1, 0, '0, 0, "R6");
        cyc(0, 1, 1, to_gray(M - 1), 1, "R7");
        cyc(0, 1, 0, '0, 0, "R6");
        cyc(0, 0, 1, '0, 0, "R7");
        cyc(0, 0, 0, '0, 0, "R2");
        cyc(0, 1, 0, '0, 0, "R5");
        cyc(1, 1, 1, 8'h5A, 0, "R1");
        cyc(0, 0, 1, 8'h3C, 0, "R9");
        for (int s = 0; s < 24; s++) begin
            int steps = 0;
            logic [W-1:0] rc = W'($urandom);
            cyc(0, 1, 1, rc, 1'($urandom), "R7");
            while (steps < M + 4) begin
                logic e = ($urandom % 4) != 0;
                cyc(0, e, 0, '0, 0, "R8");
                if (e) steps++;
                if (steps >= M + 1) begin
                    checks++;
                    if (fwd !== 1'b1) begin
                        fails++;
                        $display("FAIL R8: fwd=%0d after %0d steps expected 1", fwd, steps);
                    end
                end
            end
        end
        done = 1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: done=0 expected 1");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule